// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block gathers a parameterized set of interrupt source lines (32 by default) into one wired interrupt request for a parent interrupt controller. Each source owns one bit position in a pending-cause register, a software-set register and a mask register. One global control bit decides how every input is captured. In level mode an input that is high keeps its cause bit set. In rising-edge mode a 0-to-1 transition on an input sets its cause bit, and the bit stays set until software clears it.

Software uses a simple register port with write enable, byte address, write data and registered read data. To acknowledge a source, software writes 0 into that source's cause bit. To re-raise a source without any input activity, software writes a 1 into that bit of the set-cause register. The output request is a register that holds the OR of all cause bits whose mask bit is 0. A second control bit, which disables the message-signalled path, is stored and read back only.

Top module: `irqagg_top`

## Requirements
- R1: After reset, mask reads 0xFFFFFFFF, cause reads 0, control reads 0x00000020 and irq_out is 0.
- R2: Registers decode at byte offsets 0x00 (cause), 0x08 (set-cause), 0x10 (mask) and 0x28 (control). rdata is registered and shows the register addressed during the previous cycle. The set-cause offset and all unmapped offsets read 0.
- R3: With control bit 3 at 0 (level mode), an input that is high sets its cause bit at the next clock edge. A software clear of that bit does not hold while the input stays high.
- R4: With control bit 3 at 1 (edge mode), a 0-to-1 transition on an input sets its cause bit, and the bit stays set after the input falls. Once cleared, the bit stays clear while the input remains high, and it sets again only on the next rising transition.
- R5: A write to set-cause sets every cause bit where the write data holds 1 and leaves the other cause bits unchanged.
- R6: A write to cause replaces it with cause AND write data. Writing 0 clears all pending bits, and writing 1 in a position leaves that bit unchanged.
- R7: When a hardware set and a software clear reach the same cause bit in the same cycle, the bit ends up set.
- R8: A write to mask replaces the whole register. A mask bit of 1 keeps its source out of irq_out, and a mask bit of 0 lets the source through.
- R9: irq_out is registered and equals the OR of (cause AND NOT mask) as it stood in the previous cycle.
- R10: Control keeps only bit 3 (edge mode) and bit 5 (message path disabled). All other control bits read 0 whatever value was written.
- R11: A write to an unmapped offset, or to the set-cause offset with data 0, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Interrupt source lines, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register accessed |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Registered wired interrupt request |

## Verification
An input change or a register write that lands on clock edge N is visible in cause, mask or control from edge N onward. rdata shows that value after edge N+1, which is the edge at which the read address is captured. irq_out follows one edge after the cause change. The bench drives every stimulus on the falling edge. It applies a write for exactly one cycle and samples irq_out two falling edges after raising an input. It issues each read with its address held for one full cycle and compares on the falling edge that follows. Under this scheme each comparison falls in the first cycle in which the requirement says the result is due.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int OFS_CAUSE = 'h00;
  localparam int OFS_SETC  = 'h08;
  localparam int OFS_MASK  = 'h10;
  localparam int OFS_CTRL  = 'h28;

  localparam int CTRL_RISE_BIT = 3;
  localparam int CTRL_MSGD_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_SETC,
    SEL_MASK,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/irqagg_sampler.sv
module irqagg_sampler #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_mode,
  input  logic [N-1:0] src_in,
  output logic [N-1:0] hw_set
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (rise_mode) hw_set[i] = src_in[i] & ~src_q[i];
      else           hw_set[i] = src_in[i];
    end
  end

  // R4
  edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rise_mode && $past(rise_mode) |-> (hw_set & $past(src_in)) == '0);
endmodule

// File: rtl/irqagg_regfile.sv
module irqagg_regfile
  import irqagg_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      hw_set,
  output logic [N-1:0]      cause,
  output logic [N-1:0]      mask,
  output logic              rise_mode,
  output logic [N-1:0]      rdata
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_SETC  = ADDR_W'(OFS_SETC);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

  logic     msg_dis;
  reg_sel_e sel;
  logic [N-1:0] cause_sw;
  logic [N-1:0] ctrl_view;
  logic [N-1:0] set_word;

  always_comb begin
    unique case (addr)
      A_CAUSE: sel = SEL_CAUSE;
      A_SETC:  sel = SEL_SETC;
      A_MASK:  sel = SEL_MASK;
      A_CTRL:  sel = SEL_CTRL;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    cause_sw = cause;
    if (wr_en && sel == SEL_CAUSE) cause_sw = cause & wdata;
    if (wr_en && sel == SEL_SETC)  cause_sw = cause | wdata;
  end

  assign set_word = (wr_en && sel == SEL_SETC) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) cause <= '0;
    else     cause <= cause_sw | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst)                          mask <= '1;
    else if (wr_en && sel == SEL_MASK) mask <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_mode <= 1'b0;
      msg_dis   <= 1'b1;
    end else if (wr_en && sel == SEL_CTRL) begin
      rise_mode <= wdata[CTRL_RISE_BIT];
      msg_dis   <= wdata[CTRL_MSGD_BIT];
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_RISE_BIT] = rise_mode;
    ctrl_view[CTRL_MSGD_BIT] = msg_dis;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (sel)
        SEL_CAUSE: rdata <= cause;
        SEL_MASK:  rdata <= mask;
        SEL_CTRL:  rdata <= ctrl_view;
        default:   rdata <= '0;
      endcase
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cause & $past(hw_set)) == $past(hw_set));

  // R5
  setc_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_SETC |=> (cause & $past(wdata)) == $past(wdata));

  // R6
  cause_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_CAUSE |=> (cause & ~$past(wdata) & ~$past(hw_set)) == '0);

  // R11
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cause & ~$past(cause) & ~$past(hw_set) & ~$past(set_word)) == '0);

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_MASK |=> mask == $past(wdata));

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_MASK) |=> $stable(mask));
endmodule

// File: rtl/irqagg_irqgen.sv
module irqagg_irqgen #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cause,
  input  logic [N-1:0] mask,
  output logic         irq_out
);
  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign live[i] = cause[i] & ~mask[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |live;
  end

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past((cause & ~mask) != '0));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int N      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  output logic              irq_out
);
  logic [N-1:0] hw_set;
  logic [N-1:0] cause;
  logic [N-1:0] mask;
  logic         rise_mode;

  initial begin
    if (N < 6)      $error("irqagg_top: N must be at least 6");
    if (ADDR_W < 6) $error("irqagg_top: ADDR_W must be at least 6");
  end

  irqagg_sampler #(.N(N)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .rise_mode (rise_mode),
    .src_in    (src_in),
    .hw_set    (hw_set)
  );

  irqagg_regfile #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .hw_set    (hw_set),
    .cause     (cause),
    .mask      (mask),
    .rise_mode (rise_mode),
    .rdata     (rdata)
  );

  irqagg_irqgen #(.N(N)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .cause   (cause),
    .mask    (mask),
    .irq_out (irq_out)
  );
endmodule

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
  localparam logic [5:0] A_CAUSE = 6'h00;
  localparam logic [5:0] A_SETC  = 6'h08;
  localparam logic [5:0] A_MASK  = 6'h10;
  localparam logic [5:0] A_CTRL  = 6'h28;
  localparam logic [5:0] A_GAP   = 6'h3C;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] msk;
    logic        irq;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 32'h0000_0000, 1'b1},
    '{32'h0000_0001, 32'h0000_0001, 1'b0},
    '{32'hA5A5_0000, 32'hFFFF_0000, 1'b0},
    '{32'hA5A5_0000, 32'hFFFE_FFFF, 1'b1},
    '{32'h8000_0000, 32'h7FFF_FFFF, 1'b1},
    '{32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqagg_top dut (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    rd(A_MASK, v);  check("R1 mask", v, 32'hFFFF_FFFF);
    rd(A_CAUSE, v); check("R1 cause", v, 32'h0);
    rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0000_0020);

    // R3 R8 R9 table walk, level mode
    for (int i = 0; i < NV; i++) begin
      src_in = '0;
      wr(A_MASK, VECS[i].msk);
      wr(A_CAUSE, 32'h0);
      src_in = VECS[i].src;
      @(negedge clk);
      src_in = '0;
      @(negedge clk);
      check("R9 irq", {31'b0, irq_out}, {31'b0, VECS[i].irq});
      rd(A_CAUSE, v); check("R3 cause", v, VECS[i].src);
    end

    // R8 mask readback
    wr(A_MASK, 32'hFFFF_0000);
    rd(A_MASK, v); check("R8 mask", v, 32'hFFFF_0000);

    // R3 level input re-sets a cleared bit
    wr(A_CAUSE, 32'h0);
    src_in = 32'h0000_0010;
    @(negedge clk);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); check("R3 sticky", v, 32'h0000_0010);
    src_in = '0;
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); check("R6 clear all", v, 32'h0);

    // R6 partial ack
    wr(A_SETC, 32'h0000_0F00);
    wr(A_CAUSE, 32'hFFFF_FBFF);
    rd(A_CAUSE, v); check("R6 ack", v, 32'h0000_0B00);
    wr(A_CAUSE, 32'h0);

    // R5 set-cause and R9 irq with mask open
    wr(A_MASK, 32'h0);
    wr(A_SETC, 32'h8000_0001);
    wr(A_SETC, 32'h0000_0100);
    rd(A_CAUSE, v); check("R5 setc", v, 32'h8000_0101);
    check("R9 irq setc", {31'b0, irq_out}, 32'h1);
    wr(A_CAUSE, 32'h0);
    @(negedge clk);
    check("R9 irq low", {31'b0, irq_out}, 32'h0);

    // R10 control unused bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R10 ctrl", v, 32'h0000_0028);

    // R4 edge mode
    wr(A_CAUSE, 32'h0);
    src_in = 32'h0000_0080;
    @(negedge clk);
    rd(A_CAUSE, v); check("R4 edge set", v, 32'h0000_0080);
    src_in = '0;
    @(negedge clk);
    rd(A_CAUSE, v); check("R4 held after fall", v, 32'h0000_0080);
    src_in = 32'h0000_0080;
    @(negedge clk);
    wr(A_CAUSE, 32'h0);
    @(negedge clk);
    rd(A_CAUSE, v); check("R4 stays clear", v, 32'h0);
    src_in = '0;
    @(negedge clk);
    src_in = 32'h0000_0080;
    @(negedge clk);
    rd(A_CAUSE, v); check("R4 re-edge", v, 32'h0000_0080);
    src_in = '0;
    wr(A_CAUSE, 32'h0);

    // R7 edge and clear in the same cycle
    src_in = 32'h0000_0200;
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); check("R7 set wins", v, 32'h0000_0200);
    src_in = '0;
    wr(A_CAUSE, 32'h0);

    // R11 unmapped and zero set-cause writes
    wr(A_MASK, 32'h1234_5678);
    wr(A_SETC, 32'h0000_0040);
    wr(A_GAP, 32'hFFFF_FFFF);
    wr(A_SETC, 32'h0);
    rd(A_MASK, v);  check("R11 mask", v, 32'h1234_5678);
    rd(A_CAUSE, v); check("R11 cause", v, 32'h0000_0040);
    rd(A_CTRL, v);  check("R11 ctrl", v, 32'h0000_0028);

    // R2 reads of set-cause and unmapped offsets
    rd(A_SETC, v); check("R2 setc read", v, 32'h0);
    rd(A_GAP, v);  check("R2 gap read", v, 32'h0);

    // R10 return to level mode, message bit cleared
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); check("R10 ctrl zero", v, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule